// File: doc/BRIEF.md
# Clause 45 MDIO Management Controller

This block gives a processor memory-mapped access to the registers of PHYs on a Clause 45 MDIO bus. Software loads the 16-bit target register number into an address register, then writes a command word to the management register holding the port address, the device address, a 3-bit opcode and, for writes, 16 bits of data. A valid opcode launches a pair of frames on the bus: an address frame that carries the register number, then a data frame that either writes the data or reads 16 bits back from the PHY.

While the pair is in flight, a busy flag is raised. When it clears, a read-valid flag shows whether a PHY answered the read, and the captured data appears in the low half of the management register. A configuration register picks the MDC divide ratio from four fixed values. A new ratio is applied only at a frame boundary, so a frame never has mixed bit periods.

Top module: `mdio45_ctrl`

## Requirements
- R1: After reset, the management, address and configuration registers read 0, MDC is low and the MDIO output enable is low.
- R2: A write to the address register (offset 0x8, data in bits [15:0]) alone starts no transaction: busy stays 0 and MDC does not toggle.
- R3: A write to the management register (offset 0x0) while idle starts a transaction only when bits [28:26] hold 5 (write) or 7 (read). Busy (bit 30) then reads 1 from the next cycle. Any other opcode starts nothing.
- R4: Each transaction sends exactly two 64-bit frames, MSB first. The first is 32 ones, start 00, opcode 00, port address (command bits [20:16]), device address (bits [25:21]), turnaround 10 and the 16-bit register number.
- R5: The second frame has the same preamble, start and address fields, with opcode 01 for a write (followed by turnaround 10 and command bits [15:0]) or opcode 11 for a read.
- R6: MDIO output and output enable change only after a falling MDC edge. They never change in the cycle in which MDC rises.
- R7: In a read frame, the output enable is released for the last 18 bits (turnaround and data). The data is sampled on rising MDC edges, most significant bit first.
- R8: Read-valid (bit 29) is cleared when a command is accepted. It is set at completion of a read only if the PHY drove 0 in the second turnaround bit, and in that case bits [15:0] then return the sampled data. Otherwise bits [15:0] keep the written value.
- R9: Configuration register (offset 0xC) bits [1:0] set the MDC period in system clocks: 0 gives 256, 1 gives 64, 2 gives 32 and 3 gives 8. All 32 bits read back as written, and the reset value 0 selects 256.
- R10: A divider change written during a transaction leaves the current frame's MDC period unchanged and applies from the next frame.
- R11: Busy clears after the second frame completes. Management and address register writes made while busy are ignored.
- R12: While idle, MDC is held low and the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| mdc_o | output | 1 | MDIO management clock |
| mdio_o | output | 1 | MDIO data driven by the controller |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO data seen on the pin |

## Verification
The hardest situation to reach from the ports is a divider change that lands in the middle of a transaction. The test must show that the address frame keeps its old bit period and that the data frame uses the new one. The stimulus starts a write at the fastest ratio and waits until twenty MDC rising edges have been seen. It then writes a slower ratio, along with a competing command and a new address. The bench timestamps every MDC rising edge and compares the bit periods on both sides of the frame boundary. It also confirms that the competing writes left no trace.

// File: rtl/mdio45_pkg.sv
package mdio45_pkg;
    localparam int FRAME_BITS = 64;
    localparam int TA_IDX     = 46;
    localparam int DATA_IDX   = 48;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    localparam logic [2:0] CMD_WR = 3'd5;
    localparam logic [2:0] CMD_RD = 3'd7;

    localparam logic [3:0] OFS_MGMT = 4'h0;
    localparam logic [3:0] OFS_ADDR = 4'h8;
    localparam logic [3:0] OFS_CFG  = 4'hC;

    typedef enum logic [1:0] {SEQ_IDLE, SEQ_ADDR, SEQ_DATA} seq_e;

    // half MDC period in system clocks for each divider code
    function automatic int unsigned half_period(input logic [1:0] sel);
        case (sel)
            2'd0:    return 128;
            2'd1:    return 32;
            2'd2:    return 16;
            default: return 4;
        endcase
    endfunction
endpackage

// File: rtl/mdio45_clkdiv.sv
module mdio45_clkdiv
    import mdio45_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [1:0] sel_i,
    output logic       mdc_o,
    output logic       rise_o,
    output logic       fall_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
        logic [1:0]       sel;
    } div_t;

    div_t             s_d, s_q;
    logic [CNT_W-1:0] lim;
    logic             wrap;

    always_comb begin
        lim  = CNT_W'(half_period(s_q.sel) - 1);
        wrap = run_i && (s_q.cnt == lim);
        s_d  = s_q;
        if (!run_i) begin
            s_d.cnt = '0;
            s_d.mdc = 1'b0;
            s_d.sel = sel_i;        // divider picked up only between frames
        end else if (wrap) begin
            s_d.cnt = '0;
            s_d.mdc = ~s_q.mdc;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc_o  = s_q.mdc;
    assign rise_o = wrap && !s_q.mdc;
    assign fall_o = wrap &&  s_q.mdc;

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (s_q.cnt <= lim));
endmodule

// File: rtl/mdio45_shifter.sv
module mdio45_shifter
    import mdio45_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [FRAME_BITS-1:0] frame_i,
    input  logic                  rd_i,
    input  logic                  rise_i,
    input  logic                  fall_i,
    input  logic                  mdio_i,
    output logic                  active_o,
    output logic                  done_o,
    output logic                  mdio_o,
    output logic                  oe_o,
    output logic                  ta_o,
    output logic [15:0]           rxd_o
);
    typedef struct packed {
        logic [FRAME_BITS-1:0] sh;
        logic [IDX_W-1:0]      idx;
        logic                  act;
        logic                  rd;
        logic                  ta;
        logic [15:0]           rx;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start_i) begin
            s_d.sh  = frame_i;
            s_d.idx = '0;
            s_d.act = 1'b1;
            s_d.rd  = rd_i;
            s_d.ta  = 1'b1;
            s_d.rx  = '0;
        end else if (s_q.act) begin
            if (rise_i) begin
                if (s_q.idx == IDX_W'(TA_IDX + 1)) s_d.ta = mdio_i;
                if (s_q.idx >= IDX_W'(DATA_IDX))   s_d.rx = {s_q.rx[14:0], mdio_i};
            end
            if (fall_i) begin
                s_d.sh = {s_q.sh[FRAME_BITS-2:0], 1'b1};
                if (s_q.idx == IDX_W'(FRAME_BITS - 1)) s_d.act = 1'b0;
                else                                   s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active_o = s_q.act;
    assign done_o   = s_q.act && fall_i && (s_q.idx == IDX_W'(FRAME_BITS - 1));
    assign mdio_o   = s_q.act ? s_q.sh[FRAME_BITS-1] : 1'b1;
    assign oe_o     = s_q.act && !(s_q.rd && (s_q.idx >= IDX_W'(TA_IDX)));
    assign ta_o     = s_q.ta;
    assign rxd_o    = s_q.rx;
endmodule

// File: rtl/mdio45_ctrl.sv
module mdio45_ctrl
    import mdio45_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    input  logic              mdio_i
);
    typedef struct packed {
        seq_e        seq;
        logic        start;
        logic        valid;
        logic [2:0]  op;
        logic [4:0]  dev;
        logic [4:0]  prt;
        logic [15:0] data;
        logic [15:0] regnum;
        logic [31:0] cfg;
    } ctl_t;

    ctl_t                  s_d, s_q;
    logic                  wr, accept, busy;
    logic                  frm_act, frm_done, frm_ta, rise, fall;
    logic [15:0]           frm_rx;
    logic [FRAME_BITS-1:0] frame;
    logic [3:0]            ofs;

    assign ofs  = 4'(bus_addr_i);
    assign wr   = bus_sel_i && bus_we_i;
    assign busy = (s_q.seq != SEQ_IDLE);

    always_comb begin
        accept = wr && (ofs == OFS_MGMT) && !busy &&
                 ((bus_wdata_i[28:26] == CMD_WR) || (bus_wdata_i[28:26] == CMD_RD));
        s_d       = s_q;
        s_d.start = 1'b0;
        if (wr && (ofs == OFS_CFG)) s_d.cfg = bus_wdata_i;
        case (s_q.seq)
            SEQ_IDLE: begin
                if (wr && (ofs == OFS_ADDR)) s_d.regnum = bus_wdata_i[15:0];
                if (wr && (ofs == OFS_MGMT)) begin
                    s_d.op   = bus_wdata_i[28:26];
                    s_d.dev  = bus_wdata_i[25:21];
                    s_d.prt  = bus_wdata_i[20:16];
                    s_d.data = bus_wdata_i[15:0];
                end
                if (accept) begin
                    s_d.seq   = SEQ_ADDR;
                    s_d.start = 1'b1;
                    s_d.valid = 1'b0;
                end
            end
            SEQ_ADDR: if (frm_done) begin
                s_d.seq   = SEQ_DATA;
                s_d.start = 1'b1;
            end
            default: if (frm_done) begin
                s_d.seq = SEQ_IDLE;
                if ((s_q.op == CMD_RD) && !frm_ta) begin
                    s_d.valid = 1'b1;
                    s_d.data  = frm_rx;
                end
            end
        endcase

        if (s_q.seq == SEQ_ADDR)
            frame = {32'hFFFF_FFFF, 2'b00, 2'b00, s_q.prt, s_q.dev, 2'b10, s_q.regnum};
        else if (s_q.op == CMD_RD)
            frame = {32'hFFFF_FFFF, 2'b00, 2'b11, s_q.prt, s_q.dev, 2'b11, 16'hFFFF};
        else
            frame = {32'hFFFF_FFFF, 2'b00, 2'b01, s_q.prt, s_q.dev, 2'b10, s_q.data};

        case (ofs)
            OFS_MGMT: bus_rdata_o = {1'b0, busy, s_q.valid, s_q.op, s_q.dev, s_q.prt, s_q.data};
            OFS_ADDR: bus_rdata_o = {16'h0, s_q.regnum};
            OFS_CFG:  bus_rdata_o = s_q.cfg;
            default:  bus_rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{seq: SEQ_IDLE, default: '0};
        else        s_q <= s_d;
    end

    mdio45_clkdiv #(.CNT_W(7)) div_i (
        .clk(clk), .rst_n(rst_n), .run_i(frm_act), .sel_i(s_q.cfg[1:0]),
        .mdc_o(mdc_o), .rise_o(rise), .fall_o(fall)
    );

    mdio45_shifter shf_i (
        .clk(clk), .rst_n(rst_n), .start_i(s_q.start), .frame_i(frame),
        .rd_i((s_q.seq == SEQ_DATA) && (s_q.op == CMD_RD)),
        .rise_i(rise), .fall_i(fall), .mdio_i(mdio_i),
        .active_o(frm_act), .done_o(frm_done), .mdio_o(mdio_o), .oe_o(mdio_oe_o),
        .ta_o(frm_ta), .rxd_o(frm_rx)
    );

    // R3
    cmd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc_o && !mdio_oe_o));
    // R6
    mdio_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc_o) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));
    // R8
    valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.valid) |-> $past((s_q.seq == SEQ_DATA) && (s_q.op == CMD_RD)));
    // R11
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(frm_done));
endmodule

// File: tb/mdio45_ctrl_tb.sv
module mdio45_ctrl_tb_top;
    logic        clk = 0, rst_n = 0;
    logic        sel = 0, we = 0;
    logic [3:0]  addr = 0;
    logic [31:0] wdata = 0, rdata;
    logic        mdc, mdo, moe, mdi = 1;

    int          checks = 0, errors = 0;
    bit          finished = 0;
    int          rise_cnt = 0;
    logic [127:0] cap_d, cap_oe;
    longint      rise_t [0:127];
    logic        ta_val = 0;
    logic [15:0] phy_data = 0;

    always #10 clk = ~clk;

    mdio45_ctrl #(.ADDR_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdo),
        .mdio_oe_o(moe), .mdio_i(mdi)
    );

    // PHY model: records each bit at a rising MDC, answers after falling MDC
    always @(posedge mdc) begin
        if (rise_cnt < 128) begin
            cap_d[127-rise_cnt]  = mdo;
            cap_oe[127-rise_cnt] = moe;
            rise_t[rise_cnt]     = $time;
        end
        rise_cnt = rise_cnt + 1;
    end
    always @(negedge mdc) begin
        if (rise_cnt == 64 + 47)                          mdi = ta_val;
        else if (rise_cnt >= 112 && rise_cnt < 128)       mdi = phy_data[15-(rise_cnt-112)];
        else                                              mdi = 1'b1;
    end

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
        @(negedge clk); sel = 0; we = 0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); sel = 0; we = 0; addr = a; #1 d = rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] r;
        for (int i = 0; i < 60000; i++) begin
            bus_rd(4'h0, r);
            if (!r[30]) break;
        end
    endtask

    function automatic logic [127:0] exp_frames(input logic [2:0] op, input logic [4:0] prt,
        input logic [4:0] dev, input logic [15:0] rn, input logic [15:0] wd);
        logic [63:0] f2;
        f2 = (op == 3'd7) ? {32'hFFFFFFFF, 2'b00, 2'b11, prt, dev, 2'b11, 16'hFFFF}
                          : {32'hFFFFFFFF, 2'b00, 2'b01, prt, dev, 2'b10, wd};
        return {32'hFFFFFFFF, 2'b00, 2'b00, prt, dev, 2'b10, rn, f2};
    endfunction

    function automatic longint period_ns(input logic [1:0] s);
        case (s) 2'd0: return 256*20; 2'd1: return 64*20; 2'd2: return 32*20; default: return 8*20; endcase
    endfunction

    task automatic run_cmd(input logic [2:0] op, input logic [4:0] prt, input logic [4:0] dev,
        input logic [15:0] rn, input logic [15:0] wd, input logic ta, input logic [15:0] pd,
        input logic [1:0] dsel);
        logic [31:0]  r;
        logic [127:0] e, m;
        logic         v;
        ta_val = ta; phy_data = pd; rise_cnt = 0;
        bus_wr(4'h8, {16'h0, rn});
        bus_wr(4'h0, {3'b0, op, dev, prt, wd});
        bus_rd(4'h0, r);
        chk("R3 busy after command", r[30], 1'b1);
        chk("R8 valid cleared on accept", r[29], 1'b0);
        wait_idle();
        chk("R4 two 64-bit frames", rise_cnt, 128);
        e = exp_frames(op, prt, dev, rn, wd);
        m = (op == 3'd7) ? ~(128'h0) << 18 : ~(128'h0);
        chk((op == 3'd7) ? "R5 read frames" : "R4/R5 write frames", cap_d & m, e & m);
        chk("R7 output enable pattern", cap_oe, m);
        chk("R9 MDC period", rise_t[70] - rise_t[69], period_ns(dsel));
        v = (op == 3'd7) && !ta;
        bus_rd(4'h0, r);
        chk("R8/R11 status after completion", r,
            {1'b0, 1'b0, v, op, dev, prt, v ? pd : wd});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, cfgv;
        logic [2:0]  op;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 mdc/oe at reset", {mdc, moe}, 2'b00);
        rst_n = 1;
        bus_rd(4'h0, r); chk("R1 mgmt reset", r, 0);
        bus_rd(4'h8, r); chk("R1 addr reset", r, 0);
        bus_rd(4'hC, r); chk("R1 cfg reset", r, 0);

        // R2 address write alone does nothing
        rise_cnt = 0;
        bus_wr(4'h8, 32'h0000_1234);
        repeat (600) @(negedge clk);
        bus_rd(4'h0, r);
        chk("R2 no busy after address write", r[30], 1'b0);
        chk("R2 no MDC after address write", rise_cnt, 0);

        // R3 invalid opcode starts nothing
        bus_wr(4'h0, {3'b0, 3'd3, 5'd1, 5'd2, 16'hAAAA});
        repeat (600) @(negedge clk);
        bus_rd(4'h0, r);
        chk("R3 opcode 3 ignored (busy)", r[30], 1'b0);
        chk("R3 opcode 3 ignored (MDC)", {rise_cnt, mdc, moe}, 0);

        // R9 reset divider: 256
        run_cmd(3'd5, 5'd3, 5'd1, 16'h1234, 16'hBEEF, 1'b0, 16'h0, 2'd0);

        // R8 read with no PHY answering
        bus_wr(4'hC, 32'd3);
        run_cmd(3'd7, 5'd31, 5'd30, 16'hFFFF, 16'h5A5A, 1'b1, 16'h1357, 2'd3);
        // R7/R8 read with valid answer, boundary data
        run_cmd(3'd7, 5'd0, 5'd0, 16'h0000, 16'h0000, 1'b0, 16'h8001, 2'd3);

        // random mix
        for (int i = 0; i < 10; i++) begin
            logic [1:0] ds;
            ds   = 2'(1 + ($urandom % 3));
            cfgv = {$urandom, ds} ;
            cfgv[1:0] = ds;
            bus_wr(4'hC, cfgv);
            bus_rd(4'hC, r);
            chk("R9 cfg readback", r, cfgv);
            op = ($urandom % 2) ? 3'd7 : 3'd5;
            run_cmd(op, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom),
                    ($urandom % 4) == 0, 16'($urandom), ds);
        end

        // R10/R11 divider change and competing writes during a transaction
        bus_wr(4'hC, 32'd3);
        rise_cnt = 0; ta_val = 0;
        bus_wr(4'h8, 32'h0000_00C3);
        bus_wr(4'h0, {3'b0, 3'd5, 5'd9, 5'd17, 16'h0F0F});
        wait (rise_cnt == 20);
        bus_wr(4'hC, 32'hABCD_0002);
        bus_wr(4'h0, {3'b0, 3'd7, 5'd1, 5'd1, 16'hFFFF});
        bus_wr(4'h8, 32'h0000_7777);
        wait_idle();
        chk("R10 first frame keeps old period", rise_t[30] - rise_t[29], 64'd160);
        chk("R10 second frame uses new period", rise_t[100] - rise_t[99], 64'd640);
        chk("R11 no extra transaction", rise_cnt, 128);
        chk("R11 frames unaffected", cap_d, exp_frames(3'd5, 5'd17, 5'd9, 16'h00C3, 16'h0F0F));
        bus_rd(4'h0, r);
        chk("R11 mgmt write while busy ignored", r, {3'b000, 3'd5, 5'd9, 5'd17, 16'h0F0F});
        bus_rd(4'h8, r);
        chk("R11 address write while busy ignored", r, 32'h0000_00C3);
        bus_rd(4'hC, r);
        chk("R9 cfg written while busy", r, 32'hABCD_0002);
        repeat (50) @(negedge clk);
        chk("R12 idle pins", {mdc, moe}, 2'b00);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule